// File: doc/BRIEF.md
# SVGA Memory Bank Address Controller

This block produces the base addresses of the CPU memory window of a VGA-class display adapter. The host writes four byte-wide locations: a primary bank register, a bank extension register, and a CRTC index/data pair. From these the block derives two independent base addresses, one for CPU reads and one for CPU writes. Each base is a multiple of 64 KB with an optional bit 20, so the window can reach anywhere in up to 2 MB of display memory.

A mapping control register sits at CRTC index 0x36. Two of its bits widen the wrap mask from 256 KB to the full installed memory, which is a build parameter. A third bit selects linear mapping, and this forces both bases to zero. The bank registers keep whatever the host writes to them at all times. Any change to the control register therefore recomputes both bases at once from those stored values. Configuration writes are single-cycle strobes with no back-pressure: the block accepts every write in the cycle it is strobed, so the port is plain and not valid/ready.

Top module: `svga_bank_ctrl`

## Requirements
- R1: A write to port 0 stores the primary bank byte. Its low nibble times 0x10000 forms bits 19:16 of the write base, and its high nibble times 0x10000 forms bits 19:16 of the read base.
- R2: A write to port 1 stores the bank extension byte. Its bit 0 becomes bit 20 of the write base, and its bit 4 becomes bit 20 of the read base.
- R3: `wrap_mask` is 0x3FFFF when bits 5 and 3 of control register 0x36 are both clear. Otherwise it is MEM_KB*1024-1.
- R4: Both bases are the composed address ANDed with the mask that applies after the write.
- R5: While bit 4 of control register 0x36 is set, both bases are zero, and writes to ports 0 and 1 leave them at zero.
- R6: A write to port 3 while the index is 0x36 updates the control register and recomputes both bases and the mask from the stored bank bytes in the same update.
- R7: Bank bytes written while bit 4 is set are retained. Clearing bit 4 later yields bases built from them.
- R8: A write to port 3 while the index (last byte written to port 2) is not 0x36 changes none of the outputs.
- R9: After reset both bases are zero and the mask is 0x3FFFF.
- R10: Outputs change only on a clock edge at which `io_wr` is high. A write becomes visible after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_port | input | 2 | 0 primary bank, 1 bank extension, 2 CRTC index, 3 CRTC data |
| io_data | input | 8 | Write data |
| rd_base | output | 21 | Read window base address |
| wr_base | output | 21 | Write window base address |
| wrap_mask | output | 21 | Current display memory wrap mask |

## Verification
The bench sets bit 20 and high bank nibbles while the mask is 256 KB. A design that applies the mask late, or not at all, shows addresses above 0x3FFFF. It writes both bank registers while linear mapping is on and then turns linear mapping off. A design that drops blocked writes returns stale bases instead of the new ones. It writes data to a CRTC index other than 0x36, which catches a decoder that ignores the index. It toggles bits 3 and 5 separately, and a random phase checked against a bench model covers orderings that the fixed table misses.

// File: rtl/svga_bank_pkg.sv
package svga_bank_pkg;
  localparam int AW = 21;
  localparam logic [7:0] MAP_CTL_INDEX = 8'h36;
  localparam logic [AW-1:0] WRAP_256K = 21'h3FFFF;

  typedef enum logic [1:0] {
    PORT_BANK = 2'd0,
    PORT_EXT  = 2'd1,
    PORT_IDX  = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  // functional bits of the mapping control register
  typedef struct packed {
    logic wide_hi;  // bit 5
    logic linear;   // bit 4
    logic wide_lo;  // bit 3
  } map_ctl_t;
endpackage

// File: rtl/svga_bank_regs.sv
module svga_bank_regs
  import svga_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  port_e      port,
  input  logic [7:0] data,
  output logic [7:0] bank_d,
  output logic [1:0] ext_d,     // {rd bit20, wr bit20}
  output map_ctl_t   ctl_d,
  output map_ctl_t   ctl_q
);
  logic [7:0] bank_q;
  logic [1:0] ext_q;
  logic [7:0] idx_q;
  logic       ctl_hit;

  assign ctl_hit = wr_en && (port == PORT_DATA) && (idx_q == MAP_CTL_INDEX);

  always_comb begin
    bank_d = bank_q;
    ext_d  = ext_q;
    ctl_d  = ctl_q;
    if (wr_en && port == PORT_BANK) bank_d = data;
    if (wr_en && port == PORT_EXT)  ext_d  = {data[4], data[0]};
    if (ctl_hit) ctl_d = '{wide_hi: data[5], linear: data[4], wide_lo: data[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      ext_q  <= '0;
      idx_q  <= '0;
      ctl_q  <= '0;
    end else begin
      bank_q <= bank_d;
      ext_q  <= ext_d;
      ctl_q  <= ctl_d;
      if (wr_en && port == PORT_IDX) idx_q <= data;
    end
  end

  AST_FOREIGN_INDEX_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port == PORT_DATA && idx_q != MAP_CTL_INDEX) |=> $stable(ctl_q)); // R8
  AST_BANK_ALWAYS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port == PORT_BANK) |=> bank_q == $past(data)); // R7
endmodule

// File: rtl/svga_bank_calc.sv
module svga_bank_calc
  import svga_bank_pkg::*;
#(
  parameter int MEM_KB = 2048
) (
  input  logic [7:0]    bank,
  input  logic [1:0]    ext,
  input  map_ctl_t      ctl,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] mask
);
  localparam logic [AW-1:0] FULL_MASK = AW'(MEM_KB * 1024 - 1);

  logic [AW-1:0] rd_raw, wr_raw, wide_mask;

  assign wr_raw = {ext[0], bank[3:0], 16'h0000};
  assign rd_raw = {ext[1], bank[7:4], 16'h0000};

  generate
    if (MEM_KB <= 256) begin : g_small
      assign wide_mask = WRAP_256K;
    end else begin : g_large
      assign wide_mask = FULL_MASK;
    end
  endgenerate

  always_comb begin
    mask    = (ctl.wide_hi || ctl.wide_lo) ? wide_mask : WRAP_256K;
    rd_addr = ctl.linear ? '0 : (rd_raw & mask);
    wr_addr = ctl.linear ? '0 : (wr_raw & mask);
  end
endmodule

// File: rtl/svga_bank_ctrl.sv
module svga_bank_ctrl
  import svga_bank_pkg::*;
#(
  parameter int MEM_KB = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [1:0]    io_port,
  input  logic [7:0]    io_data,
  output logic [AW-1:0] rd_base,
  output logic [AW-1:0] wr_base,
  output logic [AW-1:0] wrap_mask
);
  localparam logic [AW-1:0] FULL_MASK = AW'(MEM_KB * 1024 - 1);

  logic [7:0]    bank_d;
  logic [1:0]    ext_d;
  map_ctl_t      ctl_d, ctl_q;
  logic [AW-1:0] rd_n, wr_n, mask_n;

  svga_bank_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (io_wr),
    .port   (port_e'(io_port)),
    .data   (io_data),
    .bank_d (bank_d),
    .ext_d  (ext_d),
    .ctl_d  (ctl_d),
    .ctl_q  (ctl_q)
  );

  svga_bank_calc #(.MEM_KB(MEM_KB)) u_calc (
    .bank    (bank_d),
    .ext     (ext_d),
    .ctl     (ctl_d),
    .rd_addr (rd_n),
    .wr_addr (wr_n),
    .mask    (mask_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_base   <= '0;
      wr_base   <= '0;
      wrap_mask <= WRAP_256K;
    end else if (io_wr) begin
      rd_base   <= rd_n;
      wr_base   <= wr_n;
      wrap_mask <= mask_n;
    end
  end

  AST_LINEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.linear |-> (rd_base == '0 && wr_base == '0)); // R5
  AST_INSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_base & ~wrap_mask) == '0) && ((wr_base & ~wrap_mask) == '0)); // R4
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_mask == WRAP_256K) || (wrap_mask == FULL_MASK)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(rd_base) && $stable(wr_base) && $stable(wrap_mask))); // R10
endmodule

// File: tb/test_svga_bank_ctrl.sv
module test_svga_bank_ctrl;
  localparam int MEM_KB = 2048;
  localparam logic [20:0] FULL = 21'(MEM_KB * 1024 - 1);
  localparam logic [20:0] W256 = 21'h3FFFF;

  typedef struct packed {
    logic [1:0]  p;
    logic [7:0]  d;
    logic [20:0] er;
    logic [20:0] ew;
    logic [20:0] em;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h53, 21'h10000,  21'h30000,  21'h3FFFF},  // R1 R4 read nibble 5 wraps
    '{2'd2, 8'h36, 21'h10000,  21'h30000,  21'h3FFFF},  // index select
    '{2'd3, 8'h20, 21'h50000,  21'h30000,  21'h1FFFFF}, // R6 R3 bit5 widens
    '{2'd1, 8'h11, 21'h150000, 21'h130000, 21'h1FFFFF}, // R2 bit 20 both
    '{2'd3, 8'h08, 21'h150000, 21'h130000, 21'h1FFFFF}, // R3 bit3 alone widens
    '{2'd3, 8'h00, 21'h10000,  21'h30000,  21'h3FFFF},  // R6 back to 256K
    '{2'd3, 8'h18, 21'h0,      21'h0,      21'h1FFFFF}, // R5 linear
    '{2'd0, 8'hA7, 21'h0,      21'h0,      21'h1FFFFF}, // R5 blocked bank
    '{2'd1, 8'h01, 21'h0,      21'h0,      21'h1FFFFF}, // R5 blocked ext
    '{2'd3, 8'h28, 21'hA0000,  21'h170000, 21'h1FFFFF}, // R7 stored values reappear
    '{2'd2, 8'h37, 21'hA0000,  21'h170000, 21'h1FFFFF}, // other index
    '{2'd3, 8'h00, 21'hA0000,  21'h170000, 21'h1FFFFF}, // R8 ignored
    '{2'd2, 8'h36, 21'hA0000,  21'h170000, 21'h1FFFFF},
    '{2'd3, 8'h00, 21'h20000,  21'h30000,  21'h3FFFF},  // R4 R6 wrap recompute
    '{2'd1, 8'h10, 21'h20000,  21'h30000,  21'h3FFFF},  // R2 R4 bit 20 masked
    '{2'd0, 8'hFF, 21'h30000,  21'h30000,  21'h3FFFF}   // R1 R4 top nibbles
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [1:0] io_port = '0;
  logic [7:0] io_data = '0;
  logic [20:0] rd_base, wr_base, wrap_mask;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [7:0] m_bank = '0, m_ext = '0, m_idx = '0, m_ctl = '0;

  always #10 clk = ~clk;

  svga_bank_ctrl #(.MEM_KB(MEM_KB)) i_svga_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .rd_base(rd_base), .wr_base(wr_base), .wrap_mask(wrap_mask)
  );

  task automatic check(input string req, input logic [20:0] er, input logic [20:0] ew,
                       input logic [20:0] em);
    total++;
    if (rd_base !== er || wr_base !== ew || wrap_mask !== em) begin
      bad++;
      $display("FAIL %s: rd=%h wr=%h mask=%h expected rd=%h wr=%h mask=%h",
               req, rd_base, wr_base, wrap_mask, er, ew, em);
    end
  endtask

  task automatic model_write(input logic [1:0] p, input logic [7:0] d);
    case (p)
      2'd0: m_bank = d;
      2'd1: m_ext = d;
      2'd2: m_idx = d;
      default: if (m_idx == 8'h36) m_ctl = d;
    endcase
  endtask

  task automatic model_out(output logic [20:0] er, output logic [20:0] ew, output logic [20:0] em);
    em = (m_ctl[5] || m_ctl[3]) ? FULL : W256;
    if (m_ctl[4]) begin
      er = '0;
      ew = '0;
    end else begin
      er = (21'(m_bank[7:4]) * 21'h10000 + (m_ext[4] ? 21'h100000 : 21'h0)) & em;
      ew = (21'(m_bank[3:0]) * 21'h10000 + (m_ext[0] ? 21'h100000 : 21'h0)) & em;
    end
  endtask

  task automatic do_write(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1;
    io_port = p;
    io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(p, d);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [20:0] er, ew, em;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", 21'h0, 21'h0, W256);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].p, VEC[i].d);
      check($sformatf("table row %0d", i), VEC[i].er, VEC[i].ew, VEC[i].em);
    end

    // R10: bus activity without strobe changes nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      io_port = 2'(i);
      io_data = 8'hC3 ^ 8'(i * 37);
    end
    @(negedge clk);
    check("R10 no strobe no change", 21'h30000, 21'h30000, W256);

    // R8: foreign index with linear bit value stays ignored
    do_write(2'd2, 8'h11);
    do_write(2'd3, 8'h3F);
    check("R8 foreign index data ignored", 21'h30000, 21'h30000, W256);

    // R5 then R7: blocked writes kept and restored
    do_write(2'd2, 8'h36);
    do_write(2'd3, 8'h10);
    check("R5 linear forces zero", 21'h0, 21'h0, W256);
    do_write(2'd0, 8'h2C);
    do_write(2'd1, 8'h10);
    check("R5 blocked writes keep zero", 21'h0, 21'h0, W256);
    do_write(2'd3, 8'h20);
    check("R7 restored after linear off", 21'h120000, 21'hC0000, FULL);

    // random sequences against bench model (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [1:0] p;
      logic [7:0] d;
      sel = int'($urandom_range(0, 7));
      d = 8'($urandom);
      if (sel < 3) p = 2'd0;
      else if (sel == 3) p = 2'd1;
      else if (sel == 4) begin
        p = 2'd2;
        if ($urandom_range(0, 4) != 0) d = 8'h36;
      end else p = 2'd3;
      do_write(p, d);
      model_out(er, ew, em);
      check($sformatf("random step %0d R4", i), er, ew, em);
    end

    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_bank = '0; m_ext = '0; m_idx = '0; m_ctl = '0;
    @(negedge clk);
    check("R9 reset mid-run", 21'h0, 21'h0, W256);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule